// File: doc/BRIEF.md
# Two-Channel Pulse-Width DAC Generator

This block drives two pulse-width modulated outputs. Each output is meant to be smoothed by an external low-pass filter into a DC level. Each channel stores its duty value in a 16-bit register, written through a simple one-cycle write strobe with a channel address. All channels share one free-running period counter. That counter advances on a tick from an enable-style prescaler, so the effective timer rate can be lowered without touching the main clock.

A single mode input selects one of two operating styles. In short mode the period is 256 ticks and only the low byte of a written duty counts. A write lands in a pending slot, which is promoted to the active slot when the counter wraps, so a period is never cut short. In long mode the period is 65536 ticks and the full 16-bit value is compared. A 10-bit setting is placed left-aligned, as the value shifted left by 6. A write replaces the active value on the next clock, so the period in progress can be truncated or lose its high phase.

Top module: `pwm_dac_pair`

## Requirements
- R1: While rst_n is low at a clock edge, all duty storage, the period counter and the prescaler clear, and both outputs are low from the next edge.
- R2: The period counter advances once every presc_div+1 clock cycles; presc_div of 0 advances it every cycle.
- R3: With mode_long low, the counter runs 0..255 and wraps to 0. An output is high exactly while the counter is below the low byte of the channel's active duty. Only bits [7:0] of a write are kept.
- R4: With mode_long low, a write goes to the channel's pending slot. The active duty takes the pending value only on the tick where the counter wraps from 255 to 0, so the output is unchanged until then.
- R5: With mode_long high, the counter runs 0..65535. An output is high exactly while the counter is below the full 16-bit active duty, so a 10-bit level N is written as N shifted left by 6.
- R6: With mode_long high, a write sets the active duty on the next clock edge, taking effect mid-period.
- R7: On the first edge where mode_long differs from the mode in use, the counter and prescaler return to 0 and each channel's pending value becomes active; a write in that same cycle is discarded.
- R8: wr_addr 0 writes channel 0 and 1 writes channel 1; a write never alters the other channel, and pwm_out[i] belongs to channel i.
- R9: An active duty of 0 holds the output low through the whole period in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_long | input | 1 | 0: 256-tick buffered mode, 1: 65536-tick immediate mode |
| presc_div | input | 8 | Prescaler divide value minus one |
| wr_en | input | 1 | Duty write strobe, one cycle |
| wr_addr | input | 1 | Channel select for the write |
| wr_data | input | 16 | Duty value to write |
| pwm_out | output | 2 | Pulse-width outputs, one per channel |

## Verification
A counter that drifts or wraps at the wrong value shows at the ports within one period. The high time and the rising-edge spacing of every output move at once. A pending value promoted too early changes the high time in the period where the write was made, not the following one. A lost copy at a mode switch shows as a wrong level on the very first cycles after the switch. The bench predicts the level of each output on every cycle from the requirements, so any of these faults is caught on the first cycle it becomes visible.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

    localparam int DUTY_W  = 16;
    localparam int SHORT_W = 8;

    typedef enum logic {
        MODE_SHORT = 1'b0,
        MODE_LONG  = 1'b1
    } pwm_mode_e;

    typedef struct packed {
        logic [DUTY_W-1:0] act;
        logic [DUTY_W-1:0] pend;
    } chan_st_t;

    typedef struct packed {
        logic [DUTY_W-1:0] cnt;
        pwm_mode_e         mode;
    } tb_st_t;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    assign tick_o = (st_q.cnt == div_i);

    always_comb begin
        st_d = st_q;
        if (clr_i || tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: a cleared prescaler restarts from zero
    p_clr_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> st_q.cnt == '0);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_dac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              mode_i,
    output logic [DUTY_W-1:0] cnt_o,
    output logic              long_o,
    output logic              chg_o,
    output logic              wrap_o
);

    localparam int HI_W = DUTY_W - SHORT_W;

    tb_st_t st_d, st_q;
    logic   at_last;

    assign chg_o   = (pwm_mode_e'(mode_i) != st_q.mode);
    assign long_o  = (st_q.mode == MODE_LONG);
    assign cnt_o   = st_q.cnt;
    assign at_last = long_o ? (&st_q.cnt) : (&st_q.cnt[SHORT_W-1:0]);
    assign wrap_o  = tick_i && !chg_o && at_last;

    always_comb begin
        st_d = st_q;
        if (chg_o) begin
            st_d.mode = pwm_mode_e'(mode_i);
            st_d.cnt  = '0;
        end else if (tick_i) begin
            if (long_o) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = {{HI_W{1'b0}}, SHORT_W'(st_q.cnt[SHORT_W-1:0] + 1'b1)};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, mode: MODE_SHORT};
        end else begin
            st_q <= st_d;
        end
    end

    // R3: short mode never leaves the 8-bit range
    p_short_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !long_o |-> st_q.cnt[DUTY_W-1:SHORT_W] == '0);

    // R2: counter only moves on a tick or a mode switch
    p_step_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !chg_o) |=> $stable(st_q.cnt));

    // R7: a mode switch restarts the period
    p_switch_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |=> st_q.cnt == '0);

endmodule

// File: rtl/pwm_dac_chan.sv
module pwm_dac_chan
    import pwm_dac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              long_i,
    input  logic              chg_i,
    input  logic              wrap_i,
    input  logic [DUTY_W-1:0] cnt_i,
    input  logic              wr_i,
    input  logic [DUTY_W-1:0] wr_data_i,
    output logic              pwm_o
);

    localparam int HI_W = DUTY_W - SHORT_W;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (chg_i) begin
            // mode switch: pending promoted, concurrent write dropped
            st_d.act = st_q.pend;
        end else if (long_i) begin
            if (wr_i) begin
                st_d.act  = wr_data_i;
                st_d.pend = wr_data_i;
            end
        end else begin
            if (wrap_i) begin
                st_d.act = st_q.pend;
            end
            if (wr_i) begin
                st_d.pend = {{HI_W{1'b0}}, wr_data_i[SHORT_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = long_i ? (cnt_i < st_q.act)
                          : (cnt_i[SHORT_W-1:0] < st_q.act[SHORT_W-1:0]);

    // R4: buffered mode holds the active duty between wraps
    p_short_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!long_i && !wrap_i && !chg_i) |=> $stable(st_q.act));

    // R6: immediate mode applies a write on the next edge
    p_long_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (long_i && !chg_i && wr_i) |=> st_q.act == $past(wr_data_i));

    // R7: pending value becomes active on a mode switch
    p_switch_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> st_q.act == $past(st_q.pend));

    // R9: zero duty never drives the output high
    p_zero_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act == '0) |-> !pwm_o);

endmodule

// File: rtl/pwm_dac_pair.sv
module pwm_dac_pair
    import pwm_dac_pkg::*;
#(
    parameter  int NCH   = 2,
    parameter  int PRE_W = 8,
    localparam int AW    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_long,
    input  logic [PRE_W-1:0]  presc_div,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DUTY_W-1:0] wr_data,
    output logic [NCH-1:0]    pwm_out
);

    logic              tick;
    logic              chg;
    logic              long_m;
    logic              wrap;
    logic [DUTY_W-1:0] cnt;

    pwm_tick_gen #(.PRE_W(PRE_W)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (chg),
        .div_i  (presc_div),
        .tick_o (tick)
    );

    pwm_timebase i_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .mode_i (mode_long),
        .cnt_o  (cnt),
        .long_o (long_m),
        .chg_o  (chg),
        .wrap_o (wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic hit;
        assign hit = wr_en && (wr_addr == AW'(g));

        pwm_dac_chan i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .long_i    (long_m),
            .chg_i     (chg),
            .wrap_i    (wrap),
            .cnt_i     (cnt),
            .wr_i      (hit),
            .wr_data_i (wr_data),
            .pwm_o     (pwm_out[g])
        );
    end

    // R8: at most one channel is addressed by a write
    p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({g_chan[1].hit, g_chan[0].hit}));

endmodule

// File: tb/test_pwm_dac_pair.sv
module test_pwm_dac_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_long = 1'b0;
    logic [7:0]  presc_div = 8'd0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_addr = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [1:0]  pwm_out;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    pwm_dac_pair i_pwm_dac_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_long (mode_long),
        .presc_div (presc_div),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pwm_out   (pwm_out)
    );

    // behavioural prediction built from the requirements
    logic [15:0] m_act [2];
    logic [15:0] m_pend[2];
    logic [15:0] m_cnt;
    logic [7:0]  m_pre;
    logic        m_long;
    logic        m_tick;
    logic        m_wrap;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_cnt <= '0; m_pre <= '0; m_long <= 1'b0;
            for (int c = 0; c < 2; c++) begin
                m_act[c] <= '0; m_pend[c] <= '0;
            end
        end else if (mode_long != m_long) begin
            m_long <= mode_long; m_cnt <= '0; m_pre <= '0;
            for (int c = 0; c < 2; c++) m_act[c] <= m_pend[c];
        end else begin
            m_tick = (m_pre == presc_div);
            m_pre <= m_tick ? 8'd0 : m_pre + 8'd1;
            m_wrap = m_tick && (m_long ? (m_cnt == 16'hFFFF) : (m_cnt[7:0] == 8'hFF));
            if (m_tick) m_cnt <= m_long ? m_cnt + 16'd1 : {8'h00, m_cnt[7:0] + 8'd1};
            for (int c = 0; c < 2; c++) begin
                if (m_long) begin
                    if (wr_en && wr_addr == c[0:0]) begin
                        m_act[c] <= wr_data; m_pend[c] <= wr_data;
                    end
                end else begin
                    if (m_wrap) m_act[c] <= m_pend[c];
                    if (wr_en && wr_addr == c[0:0]) m_pend[c] <= {8'h00, wr_data[7:0]};
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            for (int c = 0; c < 2; c++) begin
                logic exp;
                exp = m_long ? (m_cnt < m_act[c]) : (m_cnt[7:0] < m_act[c][7:0]);
                checks++;
                if (pwm_out[c] !== exp) begin
                    fails++;
                    $display("FAIL %s ch%0d cycle %0d: got %b expected %b", tag, c, cyc, pwm_out[c], exp);
                end
            end
        end
    end

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog at cycle %0d: got running expected finished", cyc);
            finish_run();
        end
    end

    initial begin
        idle(4);
        checks++;
        if (pwm_out !== 2'b00) begin
            fails++;
            $display("FAIL R1 in reset: got %b expected 00", pwm_out);
        end
        rst_n = 1'b1;
        cmp_en = 1'b1;
        tag = "R9";
        idle(300);

        // R3: sweep of duty values in short mode
        tag = "R3";
        for (int d = 0; d < 256; d += 5) begin
            wr(1'b0, 16'(d));
            wr(1'b1, 16'(255 - d));
            idle(520);
        end
        wr(1'b0, 16'hFF); wr(1'b1, 16'hFE); idle(520);
        wr(1'b0, 16'hAB05); idle(520);            // R3 upper byte dropped

        // R4: mid-period writes wait for the wrap
        tag = "R4";
        wr(1'b0, 16'h0010); idle(37);
        wr(1'b0, 16'h00F0); idle(90);
        wr(1'b1, 16'h0003); idle(600);

        // R8: one channel written, the other holds
        tag = "R8";
        wr(1'b1, 16'h0080); idle(600);
        wr(1'b0, 16'h0000); idle(600);            // R9 zero duty

        // R2: slower tick
        tag = "R2";
        wr(1'b0, 16'h0040);
        presc_div = 8'd3; idle(3000);
        presc_div = 8'd2; idle(2000);

        // R7: switch to long mode, pending copied, counter restarts
        tag = "R7";
        wr(1'b1, 16'h00C8); idle(5);
        @(negedge clk);
        mode_long = 1'b1; presc_div = 8'd0;
        idle(200);

        // R5: full 16-bit compare, left-aligned 10-bit levels
        tag = "R5";
        wr(1'b0, 16'h8000);
        wr(1'b1, 16'h0040);                        // level 1 of 1023
        idle(30000);

        // R6: immediate update truncates the period
        tag = "R6";
        wr(1'b0, 16'h2000); idle(300);
        wr(1'b1, 16'hFFC0); idle(200);
        tag = "R5";
        idle(36000);
        tag = "R6";
        wr(1'b0, 16'h0100); idle(400);

        // R7: back to short mode with the long values pending
        tag = "R7";
        @(negedge clk);
        mode_long = 1'b0;
        idle(1200);
        wr(1'b0, 16'h0077); idle(600);

        cmp_en = 1'b0;
        finish_run();
    end

endmodule